// File: doc/BRIEF.md
# Serial 8x8 Two-Dimensional DCT Engine

This block computes the two-dimensional discrete cosine transform of an 8x8 block of signed samples. Samples arrive one per cycle in raster order (row by row, column index fastest) over a valid/ready handshake. Coefficients leave one per cycle on a valid-only output. Internally, two copies of a selective one-dimensional unit do the work. Each copy evaluates exactly one output frequency of an 8-point transform per cycle, for a frequency index chosen on that cycle.

The first unit is held at one horizontal frequency u and is fed the eight stored rows in turn. Its eight results form the column of intermediate values for u directly, so no transpose memory is needed. That column is written into one half of a two-entry column buffer. While the next column fills the other half, the second unit reads the finished column and steps its own index v from 0 to 7. Output therefore runs u-major, v-minor, as one unbroken stream of 64 values. An optional truncation mode keeps only the low-frequency 4x4 corner and emits zeros everywhere else, so the output format does not change.

The controller has three states. In LOAD, ready is high and samples fill the row store. The transition LOAD to RUN fires on the edge that accepts the 64th sample. RUN lasts 64 cycles: eight phases of eight ticks, with the row unit busy throughout and the column unit busy from phase 1. The transition RUN to DRAIN fires at the end of phase 7. DRAIN lasts 8 cycles, in which the column unit finishes column 7 while ready is high again. The transition DRAIN to LOAD fires at the end of its eighth cycle.

Top module: `dct2_serial_engine`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A sample is taken on each rising edge where `in_valid` and `in_ready` are both 1. The k-th sample taken in a block (k = 0..63) is x[k/8][k%8], that is row k/8 and column k%8. Idle cycles between samples are allowed.
- R3: `in_ready` is 0 on the 64 cycles that follow the edge taking the block's final sample. It is 1 on the 65th cycle.
- R4: Let T[k][n] be 91 for k = 0. For k > 0, T[k][n] = s*M[m], where m = ((2n+1)k) mod 32, reflected to 32-m if it exceeds 16; if m then exceeds 8, it becomes 16-m and s = -1, otherwise s = +1. The table is M[1..8] = 126,118,106,91,71,49,25,0. The intermediate value is Z[r][u] = floor(sum over c of x[r][c]*T[u][c] / 256). The coefficient is Y[u][v] = floor(sum over r of Z[r][u]*T[v][r] / 256).
- R5: A block's 64 coefficients leave on 64 consecutive cycles with `out_valid` = 1, ordered Y[0][0], Y[0][1], ..., Y[0][7], Y[1][0], ..., Y[7][7].
- R6: `out_valid` first rises 9 edges after the edge that takes the block's final sample, carrying Y[0][0].
- R7: `trunc_en` is sampled only on the edge that takes the block's final sample. When that sample is 1, every Y[u][v] with u >= 4 or v >= 4 is emitted as 0, and the remaining 16 values follow R4.
- R8: Samples of the next block are accepted during the last 8 output cycles of the current block, and the next block's result is correct.
- R9: Samples offered while `in_ready` is 0, and values of `trunc_en` other than on the final-sample edge, have no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Engine can take a sample |
| in_pixel | input | IN_W | Signed sample, raster order |
| trunc_en | input | 1 | Low-frequency 4x4 mode, sampled with the final sample |
| out_valid | output | 1 | Coefficient present |
| out_coef | output | OUT_W | Signed coefficient Y[u][v] |

## Verification
The bench streams eight blocks and compares every coefficient with a transform it computes from real cosines rounded to the same 8-bit table. The patterns are a flat field, a single impulse, a ramp with idle gaps, a full-scale checkerboard and random data. A mistake in the coefficient signs or the index reflection would show up as wrong AC values on the ramp and the checkerboard. Floor-versus-round mistakes would show up on the negative checkerboard values, and a swapped phase order would put coefficients in the wrong positions. Blocks are sent back to back so that loading overlaps the drain. During the busy window the bench offers junk samples and toggles the truncation input, so a design that took those samples, or latched the mode early, would corrupt the next block. It also measures the ready-low window and the first-output latency to the exact cycle.

// File: rtl/dct2_pkg.sv
package dct2_pkg;

    localparam int BLK    = 8;
    localparam int COEF_W = 8;

    typedef enum logic [1:0] {
        S_LOAD  = 2'd0,
        S_RUN   = 2'd1,
        S_DRAIN = 2'd2
    } eng_state_t;

    // magnitude of 128*cos(m*pi/16), m = 0..8
    function automatic int cos_mag(input int m);
        int r;
        case (m)
            1: r = 126;
            2: r = 118;
            3: r = 106;
            4: r = 91;
            5: r = 71;
            6: r = 49;
            7: r = 25;
            default: r = 0;
        endcase
        return r;
    endfunction

    // signed basis weight for frequency k, sample position n
    function automatic logic signed [COEF_W-1:0] coef_val(input int k, input int n);
        int m;
        int sgn;
        int mag;
        m   = ((2 * n + 1) * k) % 32;
        sgn = 1;
        if (m > 16) m = 32 - m;
        if (m > 8) begin
            m   = 16 - m;
            sgn = -1;
        end
        mag = (k == 0) ? 91 : cos_mag(m);
        return COEF_W'(sgn * mag);
    endfunction

endpackage

// File: rtl/dct_sel_unit.sv
module dct_sel_unit
    import dct2_pkg::*;
#(
    parameter int IN_W  = 9,
    parameter int OUT_W = 12,
    parameter int SH    = 8
) (
    input  logic signed [IN_W-1:0]  vec [BLK],
    input  logic        [2:0]       idx,
    input  logic                    gate,
    output logic signed [OUT_W-1:0] y
);
    localparam int PW    = IN_W + COEF_W;
    localparam int SUM_W = PW + $clog2(BLK);

    logic signed [PW-1:0]    prod [BLK];
    logic signed [SUM_W-1:0] acc;

    genvar n, k;
    generate
        for (n = 0; n < BLK; n++) begin : g_tap
            logic signed [PW-1:0] opnd;
            logic signed [PW-1:0] cand [BLK];
            assign opnd = gate ? '0 : PW'(vec[n]);
            // one constant product per frequency; the index only selects
            for (k = 0; k < BLK; k++) begin : g_freq
                localparam logic signed [COEF_W-1:0] CV = coef_val(k, n);
                assign cand[k] = opnd * PW'(CV);
            end
            assign prod[n] = cand[idx];
        end
    endgenerate

    always_comb begin
        acc = '0;
        for (int i = 0; i < BLK; i++) begin
            acc = acc + SUM_W'(prod[i]);
        end
    end

    assign y = OUT_W'(acc >>> SH);

endmodule

// File: rtl/dct_row_bank.sv
module dct_row_bank
    import dct2_pkg::*;
#(
    parameter int IN_W = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic signed [IN_W-1:0] wr_data,
    input  logic        [2:0]      rd_row,
    output logic signed [IN_W-1:0] rd_vec [BLK],
    output logic                   blk_done
);
    localparam int CNT_W = $clog2(BLK * BLK);

    logic [CNT_W-1:0]        pix_cnt;
    logic signed [IN_W-1:0]  mem [BLK*BLK];

    always_ff @(posedge clk) begin
        if (!rst_n) pix_cnt <= '0;
        else if (wr_en) pix_cnt <= pix_cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[pix_cnt] <= wr_data;
    end

    genvar i;
    generate
        for (i = 0; i < BLK; i++) begin : g_rd
            assign rd_vec[i] = mem[{rd_row, 3'(i)}];
        end
    endgenerate

    assign blk_done = wr_en && (pix_cnt == CNT_W'(BLK * BLK - 1));

    // R2
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |=> (pix_cnt == '0));

endmodule

// File: rtl/dct_col_buf.sv
module dct_col_buf
    import dct2_pkg::*;
#(
    parameter int MID_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_bank,
    input  logic        [2:0]       wr_idx,
    input  logic signed [MID_W-1:0] wr_data,
    input  logic                    rd_en,
    input  logic                    rd_bank,
    output logic signed [MID_W-1:0] rd_vec [BLK]
);
    logic signed [MID_W-1:0] mem [2][BLK];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_bank][wr_idx] <= wr_data;
    end

    genvar i;
    generate
        for (i = 0; i < BLK; i++) begin : g_rd
            assign rd_vec[i] = mem[rd_bank][i];
        end
    endgenerate

    // R4
    bank_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en) |-> (wr_bank != rd_bank));

endmodule

// File: rtl/dct2_serial_engine.sv
module dct2_serial_engine
    import dct2_pkg::*;
#(
    parameter int IN_W = 9,
    parameter int SH   = 8,
    localparam int MID_W = IN_W + COEF_W + $clog2(BLK) - SH,
    localparam int OUT_W = MID_W + COEF_W + $clog2(BLK) - SH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [IN_W-1:0]  in_pixel,
    input  logic                    trunc_en,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_coef
);
    eng_state_t state, nxt;

    logic [3:0] phase;
    logic [2:0] tick;
    logic       blk_trunc;
    logic       s1_on, s2_on;
    logic       blk_done;
    logic       gate1, gate2;
    logic [2:0] u2;
    logic [2:0] out_u, out_v;

    logic signed [IN_W-1:0]  row_vec [BLK];
    logic signed [MID_W-1:0] col_vec [BLK];
    logic signed [MID_W-1:0] s1_y;
    logic signed [OUT_W-1:0] s2_y;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_LOAD;
        else state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_LOAD:  if (blk_done) nxt = S_RUN;
            S_RUN:   if (tick == 3'd7 && phase == 4'd7) nxt = S_DRAIN;
            S_DRAIN: if (tick == 3'd7) nxt = S_LOAD;
            default: nxt = S_LOAD;
        endcase
    end

    // state outputs
    always_comb begin
        in_ready = 1'b0;
        s1_on    = 1'b0;
        s2_on    = 1'b0;
        unique case (state)
            S_LOAD:  in_ready = 1'b1;
            S_RUN: begin
                s1_on = 1'b1;
                s2_on = (phase != 4'd0);
            end
            S_DRAIN: begin
                in_ready = 1'b1;
                s2_on    = 1'b1;
            end
            default: in_ready = 1'b0;
        endcase
    end

    // phase / tick sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= '0;
            tick      <= '0;
            blk_trunc <= 1'b0;
        end else if (state == S_LOAD) begin
            if (blk_done) begin
                phase     <= '0;
                tick      <= '0;
                blk_trunc <= trunc_en;
            end
        end else begin
            tick <= tick + 3'd1;
            if (tick == 3'd7) phase <= phase + 4'd1;
        end
    end

    assign u2    = 3'(phase - 4'd1);
    assign gate1 = blk_trunc && phase[2];
    assign gate2 = blk_trunc && (u2[2] || tick[2]);

    dct_row_bank #(.IN_W(IN_W)) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (in_valid && in_ready),
        .wr_data  (in_pixel),
        .rd_row   (tick),
        .rd_vec   (row_vec),
        .blk_done (blk_done)
    );

    dct_sel_unit #(.IN_W(IN_W), .OUT_W(MID_W), .SH(SH)) u_stage_row (
        .vec  (row_vec),
        .idx  (phase[2:0]),
        .gate (gate1),
        .y    (s1_y)
    );

    dct_col_buf #(.MID_W(MID_W)) u_cols (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (s1_on),
        .wr_bank (phase[0]),
        .wr_idx  (tick),
        .wr_data (s1_y),
        .rd_en   (s2_on),
        .rd_bank (u2[0]),
        .rd_vec  (col_vec)
    );

    dct_sel_unit #(.IN_W(MID_W), .OUT_W(OUT_W), .SH(SH)) u_stage_col (
        .vec  (col_vec),
        .idx  (tick),
        .gate (gate2),
        .y    (s2_y)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_coef  <= '0;
            out_u     <= '0;
            out_v     <= '0;
        end else begin
            out_valid <= s2_on;
            if (s2_on) begin
                out_coef <= s2_y;
                out_u    <= u2;
                out_v    <= tick;
            end
        end
    end

    // R6
    run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LOAD && blk_done) |=> (state == S_RUN && phase == 4'd0 && tick == 3'd0));

    // R5
    out_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_u == 3'd0 && out_v == 3'd0));

    // R5
    out_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> ({out_u, out_v} == $past({out_u, out_v}) + 6'd1));

    // R7
    trunc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && blk_trunc && (out_u[2] || out_v[2])) |-> (out_coef == '0));

    // R8
    drain_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DRAIN) |-> !blk_done);

endmodule

// File: tb/dct2_serial_engine_tb.sv
module dct2_serial_engine_tb;

    localparam int IN_W  = 9;
    localparam int OUT_W = 15;
    localparam int NB    = 8;
    localparam real PI   = 3.14159265358979323846;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [IN_W-1:0] in_pixel = '0;
    logic trunc_en = 1'b0;
    logic out_valid;
    logic signed [OUT_W-1:0] out_coef;

    always #2 clk = ~clk;

    dct2_serial_engine #(.IN_W(IN_W), .SH(8)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_pixel  (in_pixel),
        .trunc_en  (trunc_en),
        .out_valid (out_valid),
        .out_coef  (out_coef)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int outs = 0;
    bit mon_on = 1'b0;
    bit prev_valid = 1'b0;
    bit finished = 1'b0;

    int pix [NB][64];
    bit tmode [NB];
    int expv [NB*64];
    int acc_cyc [NB];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int tcoef(input int k, input int n);
        real v;
        if (k == 0) v = 128.0 / $sqrt(2.0);
        else v = 128.0 * $cos(real'((2 * n + 1) * k) * PI / 16.0);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    task automatic build_expected(input int b);
        int z [8][8];
        for (int r = 0; r < 8; r++)
            for (int u = 0; u < 8; u++) begin
                int s = 0;
                for (int c = 0; c < 8; c++) s += pix[b][r*8+c] * tcoef(u, c);
                z[r][u] = s >>> 8;
            end
        for (int u = 0; u < 8; u++)
            for (int v = 0; v < 8; v++) begin
                int s = 0;
                for (int r = 0; r < 8; r++) s += z[r][u] * tcoef(v, r);
                s = s >>> 8;
                if (tmode[b] && (u >= 4 || v >= 4)) s = 0;
                expv[b*64 + u*8 + v] = s;
            end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_block(input int b);
        int bad;
        for (int i = 0; i < 64; i++) begin
            if (b == 2 && (i % 5) == 4) begin
                @(negedge clk);
                in_valid = 1'b0;
                @(posedge clk);
            end
            @(negedge clk);
            while (!in_ready) begin
                in_valid = 1'b1;
                in_pixel = IN_W'(-77);
                trunc_en = ~trunc_en;
                @(posedge clk);
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_pixel = IN_W'(pix[b][i]);
            if (i == 63) begin
                trunc_en = tmode[b];
                acc_cyc[b] = cyc;
            end else begin
                trunc_en = (b == 6) ? ~tmode[b] : tmode[b];
            end
            @(posedge clk);
        end
        // R3: busy window, with junk offered (R9)
        bad = 0;
        for (int k = 1; k <= 64; k++) begin
            @(negedge clk);
            if (in_ready) bad++;
            in_valid = 1'b1;
            in_pixel = IN_W'(200 - k);
            trunc_en = k[0];
        end
        check(bad == 0, "R3 ready low 64 cycles", bad, 0);
        @(negedge clk);
        check(in_ready == 1'b1, "R3 ready back after busy", int'(in_ready), 1);
        in_valid = 1'b0;
    endtask

    // output monitor
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (outs >= NB*64) begin
                    check(1'b0, "R5 extra output", outs, NB*64);
                end else begin
                    int b;
                    b = outs / 64;
                    if ((outs % 64) == 0)
                        check(cyc - acc_cyc[b] == 10, "R6 first output latency",
                              cyc - acc_cyc[b], 10);
                    else
                        check(prev_valid, "R5 contiguous output", int'(prev_valid), 1);
                    check(int'(out_coef) == expv[outs],
                          tmode[b] ? "R7 R4 coefficient" : "R4 coefficient",
                          int'(out_coef), expv[outs]);
                end
                outs++;
            end
            prev_valid = out_valid;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", outs, NB*64);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NB; b++)
            for (int i = 0; i < 64; i++) begin
                int r, c;
                r = i / 8;
                c = i % 8;
                case (b)
                    0: pix[b][i] = 100;
                    1: pix[b][i] = (i == 0) ? 255 : 0;
                    2: pix[b][i] = (r * 8 + c) * 4 - 128;
                    3: pix[b][i] = ((r + c) % 2 == 1) ? 255 : -256;
                    7: pix[b][i] = 255;
                    default: pix[b][i] = int'($urandom_range(511, 0)) - 256;
                endcase
            end
        tmode = '{0, 0, 0, 0, 1, 0, 1, 1};
        for (int b = 0; b < NB; b++) build_expected(b);

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
        mon_on = 1'b1;

        for (int b = 0; b < NB; b++) begin
            if (b == 4) begin
                // idle gap: blocks not back to back (R2)
                repeat (20) @(posedge clk);
            end
            // other blocks start loading inside the drain window (R8)
            send_block(b);
        end

        for (int w = 0; w < 200 && outs < NB*64; w++) @(negedge clk);
        repeat (4) @(negedge clk);
        // R8 R9: every block delivered in full
        check(outs == NB*64, "R8 R9 output count", outs, NB*64);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule